// File: doc/BRIEF.md
# Phase Detector with Lock Indicator

This block compares two pulse trains that live in the reference-oscillator clock domain: a reference pulse and a divided feedback pulse. It measures the phase error in each comparison as the number of oscillator cycles between the two rising edges. From that measurement it drives a three-state charge-pump command (drive high, drive low, or high impedance). The drive polarity is selected by a polarity bit so that it matches the slope of the loop filter and the oscillator.

A lock indicator watches the measured errors. An error at or beyond an unlock threshold clears it at once. It is set again only after a run of consecutive comparisons inside a narrower lock window. A multiplexed pin carries either the lock indicator or, for monitoring, one of the two compared pulse trains. A sleep input forces the pump to high impedance and holds the lock indication high. On wake-up the detector restarts from idle with lock not yet confirmed.

Top module: `phase_lock_det`

## Requirements
- R1: With `fc_pol_i`=1, a reference rising edge seen while idle asserts `pump_up_o` from the following cycle until the feedback edge is seen. A feedback edge seen first asserts `pump_dn_o` in the same way. With `fc_pol_i`=0 the two outputs swap roles. Only one of them is asserted at a time, apart from R3.
- R2: While one input is leading, further rising edges on that same input neither end nor restart the comparison. The error keeps growing until the other input's edge arrives, so the block also detects a frequency difference.
- R3: In the cycle after a comparison completes, `pump_up_o` and `pump_dn_o` are both asserted for exactly one cycle. A comparison completes on the later edge, or on two edges that arrive in the same cycle (error 0). `pump_hiz_o` is 1 exactly when neither pump output is asserted.
- R4: The error is the number of cycles from the leading edge to the trailing edge. An error of at least UNLOCK_TH (default 4) clears the lock indication in the next cycle. The indication is also cleared once a comparison has been pending for UNLOCK_TH cycles, without waiting for the trailing edge.
- R5: The lock indication rises after CONFIRM (default 3) consecutive comparisons whose error is at most LOCK_WIN (default 2). A comparison with an error strictly between LOCK_WIN and UNLOCK_TH resets the run but leaves the indication as it is.
- R6: With `mon_sel_i`=1, `ld_pin_o` follows `ref_pulse_i` when `fc_pol_i`=1 and `fb_pulse_i` when `fc_pol_i`=0, combinationally. With `mon_sel_i`=0 it carries the lock indication.
- R7: While `sleep_i`=1, `pump_hiz_o`=1, both pump outputs are 0, and with `mon_sel_i`=0 `ld_pin_o`=1. After `sleep_i` falls, the detector is idle and the lock indication is 0 until R5 is met again.
- R8: After reset the detector is idle, `pump_hiz_o`=1 and the lock indication is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Reference-oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse_i | input | 1 | Reference pulse, rising edge used |
| fb_pulse_i | input | 1 | Divided feedback pulse, rising edge used |
| fc_pol_i | input | 1 | Pump polarity select and monitor source select |
| mon_sel_i | input | 1 | 1: monitor pulse on ld_pin_o, 0: lock indication |
| sleep_i | input | 1 | Power-save request, active high |
| pump_up_o | output | 1 | Charge pump drives high |
| pump_dn_o | output | 1 | Charge pump drives low |
| pump_hiz_o | output | 1 | Charge pump output high impedance |
| ld_pin_o | output | 1 | Lock indication or monitor pulse |

## Verification
The detector is driven with reference-leading and feedback-leading pairs, coincident edges, a burst of extra reference edges before a late feedback edge, and a reference edge whose partner never arrives. Coincident edges separate the anti-dead-zone pulse from ordinary lead pulses. The extra-edge burst shows whether a same-side edge restarts the error count. The missing partner shows that an unlock does not wait for completion. Lock runs of good, bad and in-between errors show whether the confirmation counter is cleared by the hysteresis band. Both polarities, both monitor selections and a sleep entered mid-comparison show the output mapping and the state after wake-up.

// File: rtl/pld_pkg.sv
package pld_pkg;

  typedef enum logic [1:0] {
    PD_IDLE     = 2'b00,
    PD_REF_LEAD = 2'b01,
    PD_FB_LEAD  = 2'b10
  } pd_state_e;

endpackage

// File: rtl/pld_edge_det.sv
module pld_edge_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o
);

  logic [W-1:0] prev_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[g] <= 1'b0;
      end else begin
        prev_q[g] <= sig_i[g];
      end
    end

    assign rise_o[g] = sig_i[g] & ~prev_q[g];
  end

endmodule

// File: rtl/pld_pfd_core.sv
module pld_pfd_core
  import pld_pkg::*;
#(
  parameter int UNLOCK_TH = 4,
  parameter int ERR_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_ref_i,
  input  logic             rise_fb_i,
  input  logic             sleep_i,
  output logic             meas_valid_o,
  output logic [ERR_W-1:0] meas_err_o,
  output logic             overdue_o,
  output logic             up_raw_o,
  output logic             dn_raw_o,
  output logic [ERR_W-1:0] cnt_o
);

  localparam logic [ERR_W-1:0] CNT_MAX = ERR_W'(UNLOCK_TH);
  localparam logic [ERR_W-1:0] CNT_ONE = ERR_W'(1);

  pd_state_e        state_q, state_d;
  logic [ERR_W-1:0] cnt_q, cnt_d;
  logic             adz_q, adz_d;
  logic             cnt_en;

  // next-state process
  always_comb begin
    state_d      = state_q;
    cnt_d        = cnt_q;
    adz_d        = 1'b0;
    meas_valid_o = 1'b0;
    meas_err_o   = '0;
    unique case (state_q)
      PD_IDLE: begin
        if (rise_ref_i && rise_fb_i) begin
          meas_valid_o = 1'b1;
          adz_d        = 1'b1;
        end else if (rise_ref_i) begin
          state_d = PD_REF_LEAD;
          cnt_d   = CNT_ONE;
        end else if (rise_fb_i) begin
          state_d = PD_FB_LEAD;
          cnt_d   = CNT_ONE;
        end
      end
      PD_REF_LEAD: begin
        if (rise_fb_i) begin
          meas_valid_o = 1'b1;
          meas_err_o   = cnt_q;
          adz_d        = 1'b1;
          state_d      = PD_IDLE;
        end else if (cnt_q < CNT_MAX) begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end
      PD_FB_LEAD: begin
        if (rise_ref_i) begin
          meas_valid_o = 1'b1;
          meas_err_o   = cnt_q;
          adz_d        = 1'b1;
          state_d      = PD_IDLE;
        end else if (cnt_q < CNT_MAX) begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end
      default: state_d = PD_IDLE;
    endcase
    if (sleep_i) begin
      state_d      = PD_IDLE;
      cnt_d        = '0;
      adz_d        = 1'b0;
      meas_valid_o = 1'b0;
    end
  end

  assign cnt_en = sleep_i || (state_q != PD_IDLE) || rise_ref_i || rise_fb_i;

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PD_IDLE;
      cnt_q   <= '0;
      adz_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      adz_q   <= adz_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign overdue_o = (state_q != PD_IDLE) && (cnt_q >= CNT_MAX);
  assign up_raw_o  = (state_q == PD_REF_LEAD) | adz_q;
  assign dn_raw_o  = (state_q == PD_FB_LEAD) | adz_q;
  assign cnt_o     = cnt_q;

endmodule

// File: rtl/pld_lock_det.sv
module pld_lock_det #(
  parameter int UNLOCK_TH = 4,
  parameter int LOCK_WIN  = 2,
  parameter int CONFIRM   = 3,
  parameter int ERR_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_i,
  input  logic             overdue_i,
  input  logic             meas_valid_i,
  input  logic [ERR_W-1:0] meas_err_i,
  output logic             ld_o
);

  localparam int CONF_W = $clog2(CONFIRM + 1);
  localparam logic [CONF_W-1:0] CONF_MAX  = CONF_W'(CONFIRM);
  localparam logic [CONF_W-1:0] CONF_LAST = CONF_W'(CONFIRM - 1);
  localparam logic [ERR_W-1:0]  WIN_LIM   = ERR_W'(LOCK_WIN);
  localparam logic [ERR_W-1:0]  BAD_LIM   = ERR_W'(UNLOCK_TH);

  logic [CONF_W-1:0] good_q, good_d;
  logic              ld_q, ld_d;
  logic              upd_en;

  always_comb begin
    good_d = good_q;
    ld_d   = ld_q;
    if (sleep_i || overdue_i) begin
      good_d = '0;
      ld_d   = 1'b0;
    end else if (meas_valid_i) begin
      if (meas_err_i <= WIN_LIM) begin
        if (good_q < CONF_MAX) begin
          good_d = good_q + CONF_W'(1);
        end
        if (good_q >= CONF_LAST) begin
          ld_d = 1'b1;
        end
      end else if (meas_err_i >= BAD_LIM) begin
        good_d = '0;
        ld_d   = 1'b0;
      end else begin
        good_d = '0;
      end
    end
  end

  assign upd_en = sleep_i | overdue_i | meas_valid_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q <= '0;
      ld_q   <= 1'b0;
    end else if (upd_en) begin
      good_q <= good_d;
      ld_q   <= ld_d;
    end
  end

  assign ld_o = ld_q;

endmodule

// File: rtl/pld_out_map.sv
module pld_out_map (
  input  logic fc_pol_i,
  input  logic mon_sel_i,
  input  logic sleep_i,
  input  logic up_raw_i,
  input  logic dn_raw_i,
  input  logic ref_i,
  input  logic fb_i,
  input  logic ld_i,
  output logic pump_up_o,
  output logic pump_dn_o,
  output logic pump_hiz_o,
  output logic ld_pin_o
);

  logic hi_cmd, lo_cmd, mon_sig, ld_sig;

  always_comb begin
    hi_cmd     = fc_pol_i ? up_raw_i : dn_raw_i;
    lo_cmd     = fc_pol_i ? dn_raw_i : up_raw_i;
    pump_up_o  = ~sleep_i & hi_cmd;
    pump_dn_o  = ~sleep_i & lo_cmd;
    pump_hiz_o = sleep_i | ~(up_raw_i | dn_raw_i);
    mon_sig    = fc_pol_i ? ref_i : fb_i;
    ld_sig     = sleep_i | ld_i;
    ld_pin_o   = mon_sel_i ? mon_sig : ld_sig;
  end

endmodule

// File: rtl/phase_lock_det.sv
module phase_lock_det #(
  parameter int UNLOCK_TH = 4,
  parameter int LOCK_WIN  = 2,
  parameter int CONFIRM   = 3
) (
  input  logic osc_clk,
  input  logic rst_n,
  input  logic ref_pulse_i,
  input  logic fb_pulse_i,
  input  logic fc_pol_i,
  input  logic mon_sel_i,
  input  logic sleep_i,
  output logic pump_up_o,
  output logic pump_dn_o,
  output logic pump_hiz_o,
  output logic ld_pin_o
);

  localparam int ERR_W = $clog2(UNLOCK_TH + 1);

  logic [1:0]       rise;
  logic             meas_valid;
  logic [ERR_W-1:0] meas_err;
  logic [ERR_W-1:0] cnt_q;
  logic             overdue;
  logic             up_raw, dn_raw;
  logic             ld_q;

  pld_edge_det #(.W(2)) u_edge (
    .clk   (osc_clk),
    .rst_n (rst_n),
    .sig_i ({fb_pulse_i, ref_pulse_i}),
    .rise_o(rise)
  );

  pld_pfd_core #(.UNLOCK_TH(UNLOCK_TH), .ERR_W(ERR_W)) u_core (
    .clk         (osc_clk),
    .rst_n       (rst_n),
    .rise_ref_i  (rise[0]),
    .rise_fb_i   (rise[1]),
    .sleep_i     (sleep_i),
    .meas_valid_o(meas_valid),
    .meas_err_o  (meas_err),
    .overdue_o   (overdue),
    .up_raw_o    (up_raw),
    .dn_raw_o    (dn_raw),
    .cnt_o       (cnt_q)
  );

  pld_lock_det #(
    .UNLOCK_TH(UNLOCK_TH), .LOCK_WIN(LOCK_WIN), .CONFIRM(CONFIRM), .ERR_W(ERR_W)
  ) u_lock (
    .clk         (osc_clk),
    .rst_n       (rst_n),
    .sleep_i     (sleep_i),
    .overdue_i   (overdue),
    .meas_valid_i(meas_valid),
    .meas_err_i  (meas_err),
    .ld_o        (ld_q)
  );

  pld_out_map u_out (
    .fc_pol_i  (fc_pol_i),
    .mon_sel_i (mon_sel_i),
    .sleep_i   (sleep_i),
    .up_raw_i  (up_raw),
    .dn_raw_i  (dn_raw),
    .ref_i     (ref_pulse_i),
    .fb_i      (fb_pulse_i),
    .ld_i      (ld_q),
    .pump_up_o (pump_up_o),
    .pump_dn_o (pump_dn_o),
    .pump_hiz_o(pump_hiz_o),
    .ld_pin_o  (ld_pin_o)
  );

endmodule

// File: rtl/pld_checker.sv
module pld_checker #(
  parameter int UNLOCK_TH = 4,
  parameter int LOCK_WIN  = 2,
  parameter int ERR_W     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep_i,
  input logic             mon_sel_i,
  input logic             pump_up,
  input logic             pump_dn,
  input logic             pump_hiz,
  input logic             ld_pin,
  input logic             meas_valid,
  input logic [ERR_W-1:0] meas_err,
  input logic             ld_q,
  input logic             up_raw,
  input logic             dn_raw,
  input logic [ERR_W-1:0] cnt_q
);

  a_r7_sleep_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |-> (pump_hiz && !pump_up && !pump_dn));

  a_r7_ld_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_i && !mon_sel_i) |-> ld_pin);

  a_r4_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid && (meas_err >= ERR_W'(UNLOCK_TH))) |=> !ld_q);

  a_r5_lock_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ld_q) |-> ($past(meas_valid) && ($past(meas_err) <= ERR_W'(LOCK_WIN))));

  a_r3_adz_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid && !sleep_i) |=> (sleep_i || (up_raw && dn_raw)));

  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ERR_W'(UNLOCK_TH));

  a_r3_hiz_excl: assert property (@(posedge clk) disable iff (!rst_n)
    pump_hiz |-> !(pump_up || pump_dn));

endmodule

bind phase_lock_det pld_checker #(
  .UNLOCK_TH(UNLOCK_TH), .LOCK_WIN(LOCK_WIN), .ERR_W(ERR_W)
) u_chk (
  .clk       (osc_clk),
  .rst_n     (rst_n),
  .sleep_i   (sleep_i),
  .mon_sel_i (mon_sel_i),
  .pump_up   (pump_up_o),
  .pump_dn   (pump_dn_o),
  .pump_hiz  (pump_hiz_o),
  .ld_pin    (ld_pin_o),
  .meas_valid(meas_valid),
  .meas_err  (meas_err),
  .ld_q      (ld_q),
  .up_raw    (up_raw),
  .dn_raw    (dn_raw),
  .cnt_q     (cnt_q)
);

// File: tb/phase_lock_det_tb_top.sv
`timescale 1ns/1ps
module phase_lock_det_tb_top;

  localparam int UNLK = 4;
  localparam int LWIN = 2;
  localparam int CONF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fr = 1'b0, fp = 1'b0, fc = 1'b1, lds = 1'b0, slp = 1'b0;
  logic pu, pd, ph, ldp;

  always #2 clk = ~clk;

  phase_lock_det #(.UNLOCK_TH(UNLK), .LOCK_WIN(LWIN), .CONFIRM(CONF)) dut_i (
    .osc_clk(clk), .rst_n(rst_n), .ref_pulse_i(fr), .fb_pulse_i(fp),
    .fc_pol_i(fc), .mon_sel_i(lds), .sleep_i(slp),
    .pump_up_o(pu), .pump_dn_o(pd), .pump_hiz_o(ph), .ld_pin_o(ldp)
  );

  int checks = 0;
  int errs = 0;
  bit done = 1'b0;

  // behavioural reference model
  int m_pend;   // 0 idle, 1 reference leads, 2 feedback leads
  int m_cnt;
  int m_good;
  bit m_adz, m_ld, m_pfr, m_pfp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_cnt = 0; m_good = 0;
      m_adz = 0; m_ld = 0; m_pfr = 0; m_pfp = 0;
    end else begin
      bit rf, rp, fin, late;
      int e;
      rf = fr && !m_pfr;
      rp = fp && !m_pfp;
      m_pfr = fr;
      m_pfp = fp;
      late = (m_pend != 0) && (m_cnt >= UNLK);
      fin = 0;
      e = 0;
      if (slp) begin
        m_pend = 0; m_cnt = 0; m_adz = 0; m_good = 0; m_ld = 0;
      end else begin
        if (m_pend == 0) begin
          if (rf && rp) fin = 1;
          else if (rf) begin m_pend = 1; m_cnt = 1; end
          else if (rp) begin m_pend = 2; m_cnt = 1; end
        end else if ((m_pend == 1 && rp) || (m_pend == 2 && rf)) begin
          fin = 1; e = m_cnt; m_pend = 0;
        end else if (m_cnt < UNLK) begin
          m_cnt++;
        end
        m_adz = fin;
        if (late) begin
          m_ld = 0; m_good = 0;
        end else if (fin) begin
          if (e <= LWIN) begin
            if (m_good < CONF) m_good++;
            if (m_good >= CONF) m_ld = 1;
          end else if (e >= UNLK) begin
            m_ld = 0; m_good = 0;
          end else begin
            m_good = 0;
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  // compare every cycle, 1 ns after the rising edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      bit hi, lo, eu, ed, eh, el;
      hi = (m_pend == 1) || m_adz;
      lo = (m_pend == 2) || m_adz;
      eu = !slp && (fc ? hi : lo);
      ed = !slp && (fc ? lo : hi);
      eh = slp || !(hi || lo);
      el = lds ? (fc ? fr : fp) : (slp || m_ld);
      chk("R1 R2 pump_up", pu, eu);
      chk("R1 R2 pump_dn", pd, ed);
      chk("R3 pump_hiz", ph, eh);
      chk(lds ? "R6 ld_pin" : (slp ? "R7 ld_pin" : "R4 R5 ld_pin"), ldp, el);
    end
  end

  task automatic seq(input logic [15:0] a, input logic [15:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fr = a[i];
      fp = b[i];
    end
    @(negedge clk);
    fr = 1'b0;
    fp = 1'b0;
  endtask

  task automatic look(input string tag, input logic exp);
    @(posedge clk);
    #1;
    chk(tag, ldp, exp);
  endtask

  task automatic good3();
    for (int k = 0; k < 3; k++) seq(16'h0001, 16'h0002, 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 hiz in reset", ph, 1'b1);
    chk("R8 ld in reset", ldp, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    look("R8 ld after reset", 1'b0);
    chk("R8 hiz after reset", ph, 1'b1);

    good3();
    look("R5 lock after three good", 1'b1);

    seq(16'h0001, 16'h0020, 10);
    look("R4 unlock on error 5", 1'b0);

    seq(16'h0001, 16'h0002, 6);
    seq(16'h0001, 16'h0002, 6);
    seq(16'h0001, 16'h0008, 8);
    seq(16'h0001, 16'h0002, 6);
    seq(16'h0001, 16'h0002, 6);
    look("R5 run reset by error 3", 1'b0);
    seq(16'h0001, 16'h0002, 6);
    look("R5 lock after fresh run", 1'b1);

    seq(16'h0004, 16'h0001, 8);
    look("R1 feedback lead error 2 keeps lock", 1'b1);
    seq(16'h0002, 16'h0002, 6);
    look("R3 coincident edges keep lock", 1'b1);

    seq(16'h0015, 16'h0040, 10);
    look("R2 extra reference edges do not restart", 1'b0);

    good3();
    look("R5 relock", 1'b1);
    seq(16'h0001, 16'h0000, 8);
    look("R4 overdue unlock without trailing edge", 1'b0);
    seq(16'h0000, 16'h0001, 4);

    fc = 1'b0;
    good3();
    seq(16'h0004, 16'h0001, 8);
    look("R5 lock with inverted polarity", 1'b1);

    lds = 1'b1;
    fc = 1'b1;
    seq(16'h0003, 16'h0004, 8);
    @(negedge clk);
    fr = 1'b1;
    #1 chk("R6 monitor follows reference", ldp, 1'b1);
    fc = 1'b0;
    #1 chk("R6 monitor follows feedback", ldp, 1'b0);
    @(negedge clk);
    fr = 1'b0;
    seq(16'h0004, 16'h0003, 8);
    fc = 1'b1;

    lds = 1'b0;
    good3();
    seq(16'h0001, 16'h0000, 2);
    @(negedge clk);
    slp = 1'b1;
    look("R7 ld forced high in sleep", 1'b1);
    chk("R7 pump hiz in sleep", ph, 1'b1);
    seq(16'h0001, 16'h0004, 6);
    @(negedge clk);
    slp = 1'b0;
    look("R7 lock cleared after wake", 1'b0);
    chk("R7 idle after wake", ph, 1'b1);
    good3();
    look("R7 relock after wake", 1'b1);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errs++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

endmodule